// File: doc/BRIEF.md
# Dual-Output Phase-Frequency Detector with Lock Monitor

This block compares the timing of two divider output edges, one from the reference divider and one from the feedback (main) divider, each presented as a one-cycle strobe on the sampling clock. When the reference edge comes first, it raises a source (up) request for the normal charge pump. When the feedback edge comes first, it raises a sink (down) request. The request lasts as long as the gap between the two edges. When the later edge arrives, the opposite request is also raised, and both are held together for a fixed minimum width. This keeps the detector gain linear near zero phase error. A second pair of requests drives a fast pump. The fast pair copies the normal pair only while the fast-mode input is enabled. That enable is taken only between comparisons, so a pulse is never cut short.

A 2-bit current-ratio code is decoded into a 3-bit relative magnitude for each pump. A lock monitor measures every completed comparison. It flags lock when the measured edge gap, in sampling-clock cycles, is below a threshold parameter. The lock output is held high whenever lock monitoring is switched off. A power-enable input idles the whole detector while it is low.

Top module: `dual_pfd_lock`

## Requirements
- R1: After reset, all four pump requests are low and `lock` is high.
- R2: When `ref_tick` leads `div_tick` by k≥1 cycles, `up_n` is high for k+MIN_W consecutive cycles, starting in the cycle after the first tick is sampled. `dn_n` is high only for the final MIN_W of those cycles, and both drop in the same cycle.
- R3: When `div_tick` leads `ref_tick` by k≥1 cycles, the behaviour mirrors R2: `dn_n` is high for k+MIN_W cycles and `up_n` for the final MIN_W cycles.
- R4: When both ticks are sampled in the same cycle, `up_n` and `dn_n` are both high for exactly MIN_W cycles.
- R5: A repeated leading tick before the other edge arrives is ignored. So is any tick sampled while both requests are high. Neither changes the pulse widths.
- R6: While `pwr_on` is low, all pump requests are low from the next cycle on, and ticks produce no pulse.
- R7: When fast mode is in effect, `up_f`/`dn_f` equal `up_n`/`dn_n`. Otherwise they stay low.
- R8: `fast_req` is sampled only in cycles where both normal requests are low. A change during a pulse takes effect from the next comparison.
- R9: `mag_n` is 2 for codes 00 and 01 and 1 for codes 10 and 11. `mag_f` gives the fast multiple divided by 4: 2, 4, 3 and 4 for codes 00, 01, 10 and 11 respectively.
- R10: With `lock_en` high, each completed comparison with gap k sets `lock` to (k < LOCK_THR). The new value is visible within two cycles of the later tick.
- R11: With `lock_en` low, `lock` is high in the same cycle, whatever the measured error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | Detector powered when high |
| ref_tick | input | 1 | One-cycle strobe at a reference divider edge |
| div_tick | input | 1 | One-cycle strobe at a feedback divider edge |
| fast_req | input | 1 | Request for fast pump operation |
| lock_en | input | 1 | Enables the lock monitor |
| cur_code | input | 2 | Pump current ratio selection |
| up_n | output | 1 | Normal pump source request |
| dn_n | output | 1 | Normal pump sink request |
| up_f | output | 1 | Fast pump source request |
| dn_f | output | 1 | Fast pump sink request |
| mag_n | output | 3 | Normal pump relative current |
| mag_f | output | 3 | Fast pump relative current, in units of four |
| lock | output | 1 | Lock indication |

## Verification
If the lead-state register is wrong, the leading request's width is wrong, which shows within one comparison of MIN_W plus the gap. A hold counter that stops at the wrong count changes the trailing width and the joint-release cycle, so it shows on the very first comparison. A fast-enable latch that updates during a pulse shows as a fast request turning on or off in the middle of a normal request. A measured gap that is off by one shows only at the threshold boundary, so gaps of LOCK_THR-1 and LOCK_THR are driven on purpose.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PD_IDLE = 2'd0,
        PD_REF_LEAD = 2'd1,
        PD_DIV_LEAD = 2'd2,
        PD_HOLD = 2'd3
    } pd_state_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;

    function automatic logic [2:0] norm_mag(input logic [1:0] code);
        return code[1] ? 3'd1 : 3'd2;
    endfunction

    function automatic logic [2:0] fast_mag(input logic [1:0] code);
        logic [2:0] m;
        case (code)
            2'b00: m = 3'd2;
            2'b01: m = 3'd4;
            2'b10: m = 3'd3;
            default: m = 3'd4;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
    parameter int MIN_W = 3,
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_on,
    input  logic                  ref_tick,
    input  logic                  div_tick,
    output pfd_pkg::pump_req_t    req,
    output logic                  cmp_done,
    output logic [CNT_W-1:0]      err_w
);
    import pfd_pkg::*;

    localparam int HOLD_W = (MIN_W < 2) ? 1 : $clog2(MIN_W);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(MIN_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    pd_state_e state_q;
    logic [HOLD_W-1:0] hold_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            state_q  <= PD_IDLE;
            hold_q   <= '0;
            cnt_q    <= '0;
            cmp_done <= 1'b0;
            err_w    <= '0;
        end else begin
            cmp_done <= 1'b0;
            case (state_q)
                PD_IDLE: begin
                    if (ref_tick && div_tick) begin
                        state_q  <= PD_HOLD;
                        hold_q   <= HOLD_LOAD;
                        cmp_done <= 1'b1;
                        err_w    <= '0;
                    end else if (ref_tick) begin
                        state_q <= PD_REF_LEAD;
                        cnt_q   <= CNT_W'(1);
                    end else if (div_tick) begin
                        state_q <= PD_DIV_LEAD;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                PD_REF_LEAD, PD_DIV_LEAD: begin
                    if ((state_q == PD_REF_LEAD && div_tick) ||
                        (state_q == PD_DIV_LEAD && ref_tick)) begin
                        state_q  <= PD_HOLD;
                        hold_q   <= HOLD_LOAD;
                        cmp_done <= 1'b1;
                        err_w    <= cnt_q;
                    end else if (cnt_q != CNT_MAX) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (hold_q == '0) begin
                        state_q <= PD_IDLE;
                    end else begin
                        hold_q <= hold_q - 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        req.up = (state_q == PD_REF_LEAD) || (state_q == PD_HOLD);
        req.dn = (state_q == PD_DIV_LEAD) || (state_q == PD_HOLD);
    end

endmodule

// File: rtl/pfd_fast_gate.sv
module pfd_fast_gate (
    input  logic               clk,
    input  logic               rst,
    input  logic               fast_req,
    input  pfd_pkg::pump_req_t req_n,
    output pfd_pkg::pump_req_t req_f
);
    logic fast_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_q <= 1'b0;
        end else if (!req_n.up && !req_n.dn) begin
            fast_q <= fast_req;
        end
    end

    always_comb begin
        req_f.up = req_n.up && fast_q;
        req_f.dn = req_n.dn && fast_q;
    end

endmodule

// File: rtl/pfd_lock_meter.sv
module pfd_lock_meter #(
    parameter int CNT_W    = 8,
    parameter int LOCK_THR = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_done,
    input  logic [CNT_W-1:0] err_w,
    output logic             in_lock
);
    localparam logic [CNT_W-1:0] THR = CNT_W'(LOCK_THR);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_lock <= 1'b1;
        end else if (cmp_done) begin
            in_lock <= (err_w < THR);
        end
    end

endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
    parameter int MIN_W    = 3,
    parameter int CNT_W    = 8,
    parameter int LOCK_THR = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_on,
    input  logic       ref_tick,
    input  logic       div_tick,
    input  logic       fast_req,
    input  logic       lock_en,
    input  logic [1:0] cur_code,
    output logic       up_n,
    output logic       dn_n,
    output logic       up_f,
    output logic       dn_f,
    output logic [2:0] mag_n,
    output logic [2:0] mag_f,
    output logic       lock
);
    import pfd_pkg::*;

    pump_req_t req_n;
    pump_req_t req_f;
    logic cmp_done;
    logic [CNT_W-1:0] err_w;
    logic in_lock;

    pfd_core #(.MIN_W(MIN_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .pwr_on(pwr_on),
        .ref_tick(ref_tick), .div_tick(div_tick),
        .req(req_n), .cmp_done(cmp_done), .err_w(err_w)
    );

    pfd_fast_gate u_fast (
        .clk(clk), .rst(rst), .fast_req(fast_req),
        .req_n(req_n), .req_f(req_f)
    );

    pfd_lock_meter #(.CNT_W(CNT_W), .LOCK_THR(LOCK_THR)) u_lock (
        .clk(clk), .rst(rst), .cmp_done(cmp_done),
        .err_w(err_w), .in_lock(in_lock)
    );

    always_comb begin
        up_n  = req_n.up;
        dn_n  = req_n.dn;
        up_f  = req_f.up;
        dn_f  = req_f.dn;
        mag_n = norm_mag(cur_code);
        mag_f = fast_mag(cur_code);
        lock  = lock_en ? in_lock : 1'b1;
    end

endmodule

// File: rtl/dual_pfd_lock_chk.sv
module dual_pfd_lock_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_on,
    input logic       lock_en,
    input logic       up_n,
    input logic       dn_n,
    input logic       up_f,
    input logic       dn_f,
    input logic [2:0] mag_n,
    input logic       lock
);
    // R6
    pwr_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_on |=> (!up_n && !dn_n));

    // R2
    joint_release_up_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(up_n) |-> !dn_n);

    // R3
    joint_release_dn_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dn_n) |-> !up_n);

    // R7
    fast_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (up_f |-> up_n) and (dn_f |-> dn_n));

    // R8
    fast_no_cut_up_chk: assert property (@(posedge clk) disable iff (rst)
        (up_n && $past(up_n)) |-> $stable(up_f));

    // R8
    fast_no_cut_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_n && $past(dn_n)) |-> $stable(dn_f));

    // R11
    lock_forced_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_en |-> lock);

    // R9
    always_comb begin
        if (!rst) begin
            norm_mag_range_chk: assert (mag_n == 3'd1 || mag_n == 3'd2);
        end
    end

endmodule

bind dual_pfd_lock dual_pfd_lock_chk u_chk (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .lock_en(lock_en),
    .up_n(up_n), .dn_n(dn_n), .up_f(up_f), .dn_f(dn_f),
    .mag_n(mag_n), .lock(lock)
);

// File: tb/dual_pfd_lock_tb.sv
module dual_pfd_lock_tb;
    localparam int MIN_W = 3;
    localparam int LOCK_THR = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_on = 1'b1;
    logic ref_tick = 1'b0;
    logic div_tick = 1'b0;
    logic fast_req = 1'b0;
    logic lock_en = 1'b1;
    logic [1:0] cur_code = 2'b00;
    logic up_n, dn_n, up_f, dn_f, lock;
    logic [2:0] mag_n, mag_f;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dual_pfd_lock #(.MIN_W(MIN_W), .CNT_W(8), .LOCK_THR(LOCK_THR)) u_dut (
        .clk(clk), .rst(rst), .pwr_on(pwr_on), .ref_tick(ref_tick),
        .div_tick(div_tick), .fast_req(fast_req), .lock_en(lock_en),
        .cur_code(cur_code), .up_n(up_n), .dn_n(dn_n), .up_f(up_f),
        .dn_f(dn_f), .mag_n(mag_n), .mag_f(mag_f), .lock(lock)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_mag_n(input int code);
        return (code >= 2) ? 1 : 2;
    endfunction

    function automatic int exp_mag_f(input int code);
        int mult[4] = '{8, 16, 12, 16};
        return mult[code] / 4;
    endfunction

    // One comparison: leading edge at cycle 0, trailing edge at cycle k.
    // lead: 0 = reference leads, 1 = feedback leads.
    // rep_at: cycle of a repeated leading tick (-1 none).
    // hold_at: cycle of a double tick while both requests are high (-1 none).
    // flip: toggle fast_req at cycle 1.
    task automatic run_cmp(input int k, input int lead, input bit fast,
                           input bit en, input int rep_at, input int hold_at,
                           input bit flip);
        int cu = 0, cd = 0, cfu = 0, cfd = 0, first_lead = -1;
        int n_lead, n_trail, exp_fast;
        string rq;
        @(negedge clk);
        fast_req = fast;
        lock_en = en;
        @(negedge clk);
        for (int c = 0; c < k + MIN_W + 4; c++) begin
            @(negedge clk);
            cu  += up_n;  cd  += dn_n;
            cfu += up_f;  cfd += dn_f;
            if (first_lead < 0 && ((lead == 0) ? up_n : dn_n)) first_lead = c;
            ref_tick = 1'b0;
            div_tick = 1'b0;
            if (c == 0 || c == rep_at) begin
                if (lead == 0) ref_tick = 1'b1; else div_tick = 1'b1;
            end
            if (c == k) begin
                if (lead == 0) div_tick = 1'b1; else ref_tick = 1'b1;
            end
            if (c == hold_at) begin
                ref_tick = 1'b1;
                div_tick = 1'b1;
            end
            if (c == 1 && flip) fast_req = !fast_req;
        end
        rq = (k == 0) ? "R4" : ((lead == 0) ? "R2" : "R3");
        if (rep_at >= 0 || hold_at >= 0) rq = "R5";
        n_lead = (lead == 0) ? cu : cd;
        n_trail = (lead == 0) ? cd : cu;
        check(rq, n_lead, k + MIN_W);
        check(rq, n_trail, MIN_W);
        check(rq, first_lead, 1);
        exp_fast = fast ? 1 : 0;
        check(flip ? "R8" : "R7", cfu, exp_fast * cu);
        check(flip ? "R8" : "R7", cfd, exp_fast * cd);
        if (en) check("R10", lock, (k < LOCK_THR) ? 1 : 0);
        else    check("R11", lock, 1);
    endtask

    initial begin
        int seed_dummy;
        int cu, cd;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1", up_n, 0); check("R1", dn_n, 0);
        check("R1", up_f, 0); check("R1", dn_f, 0);
        check("R1", lock, 1);

        // R9
        for (int code = 0; code < 4; code++) begin
            cur_code = code[1:0];
            #1;
            check("R9", int'(mag_n), exp_mag_n(code));
            check("R9", int'(mag_f), exp_mag_f(code));
        end

        // Directed: R2, R3, R4, lock boundary R10
        run_cmp(4, 0, 1'b0, 1'b1, -1, -1, 1'b0);
        run_cmp(5, 1, 1'b1, 1'b1, -1, -1, 1'b0);
        run_cmp(0, 0, 1'b1, 1'b1, -1, -1, 1'b0);
        run_cmp(LOCK_THR - 1, 0, 1'b0, 1'b1, -1, -1, 1'b0);
        run_cmp(LOCK_THR, 1, 1'b0, 1'b1, -1, -1, 1'b0);
        run_cmp(1, 0, 1'b0, 1'b1, -1, -1, 1'b0);
        // R11: large error while disabled
        run_cmp(12, 0, 1'b0, 1'b0, -1, -1, 1'b0);
        // R5: repeated leading tick, tick during joint hold
        run_cmp(5, 0, 1'b0, 1'b1, 2, -1, 1'b0);
        run_cmp(3, 1, 1'b0, 1'b1, -1, 4, 1'b0);
        // R8: fast request changes mid-pulse
        run_cmp(6, 0, 1'b0, 1'b1, -1, -1, 1'b1);
        run_cmp(3, 0, 1'b1, 1'b1, -1, -1, 1'b1);

        // R6: power-down cuts a pulse and blocks new ones
        @(negedge clk);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
        check("R6", up_n, 1);
        pwr_on = 1'b0;
        @(negedge clk);
        check("R6", up_n, 0);
        cu = 0; cd = 0;
        for (int c = 0; c < 8; c++) begin
            ref_tick = (c == 1);
            div_tick = (c == 3);
            @(negedge clk);
            cu += up_n; cd += dn_n;
        end
        ref_tick = 1'b0; div_tick = 1'b0;
        check("R6", cu, 0);
        check("R6", cd, 0);
        pwr_on = 1'b1;
        run_cmp(2, 1, 1'b0, 1'b1, -1, -1, 1'b0);

        // Random mix
        for (int i = 0; i < 40; i++) begin
            run_cmp($urandom_range(0, 14), $urandom_range(0, 1),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    -1, -1, 1'($urandom_range(0, 1)));
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule